// File: doc/BRIEF.md
# Word-Serial Configuration Stream Loader

This block loads a configuration image into a programmable logic device that accepts the image as 16-bit words on a write port. The image arrives as a byte stream with valid/ready flow control and an end-of-image flag. Leading header bytes are thrown away up to a two-byte start marker. From the marker onward, byte pairs are packed into words and written one at a time. Each write is paced by a handshake with the device status.

A start pulse first runs a validation pass over the whole image. This pass confirms that the marker is present and that the remainder has an even length, and it does so before the device is touched. Each programming attempt then does the following in order: it pulses the program output, waits for the device to report init, and asks the byte source to replay the image from its first byte. It then streams the words and finally waits for the done input. A failed attempt is repeated up to a fixed number of times. The outcome code is held until the next start.

Top module: `cfg_stream_loader`

## Requirements
- R1: Every byte before the first 0xFF that is directly followed by 0x20 is discarded; that 0xFF/0x20 pair forms the first written word, 16'hFF20, and a lone 0xFF or an earlier 0xFF not followed by 0x20 is discarded as header.
- R2: If the image ends without the marker, result_o becomes 1 (bad image), finish_o pulses, and prog_o never rises.
- R3: If the byte count from the 0xFF of the marker through the last byte is odd, result_o becomes 1 (bad image) and prog_o never rises.
- R4: Each word is packed big-endian: the earlier byte goes to wr_data_o[15:8] and the later byte to wr_data_o[7:0]; words are written in stream order with wr_en_o high for exactly one cycle.
- R5: Each attempt holds prog_o high for (PROG_TICKS-1)*POLL_CYCLES+1 cycles and then polls status bit 1 (init) once every POLL_CYCLES cycles, at most INIT_POLLS times; if init is never seen, the attempt fails with code 2 (init timeout).
- R6: When status bits 15:12 read 4'h5 at the moment init is seen, status bit 2 (tx-ready) must be seen within TX_POLLS polls before each word is written, or the attempt fails with code 3. For any other value, a fixed wait of WRITE_DELAY_TICKS poll intervals precedes each write.
- R7: Status bit 1 is sampled in the cycle after each word write; if it is low, the attempt fails with code 3 (write error).
- R8: After the last word, dev_done_i is polled at most DONE_POLLS times; seeing it gives result 0 (success), and missing it fails the attempt with code 4 (done timeout).
- R9: A failed attempt is retried until MAX_TRIES attempts have been made; the first success stops the sequence. Every attempt begins with one prog_o pulse, and the image is replayed from its first byte after a rewind_o pulse.
- R10: finish_o pulses for one cycle as busy_o falls, and result_o then holds its value until the next accepted start_i.
- R11: While idle, s_ready_o stays low, so offered bytes are neither consumed nor written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted while idle |
| s_valid_i | input | 1 | Image byte valid |
| s_data_i | input | 8 | Image byte |
| s_last_i | input | 1 | Marks the final image byte |
| s_ready_o | output | 1 | Byte accepted when high with s_valid_i |
| rewind_o | output | 1 | Requests the source to restart the image from its first byte |
| prog_o | output | 1 | Program pulse to the device, active high |
| dev_status_i | input | 16 | Device status: bit 1 init, bit 2 tx-ready, bits 15:12 version |
| dev_done_i | input | 1 | Device reports configuration complete |
| wr_en_o | output | 1 | Word write strobe |
| wr_data_o | output | 16 | Word to write |
| busy_o | output | 1 | Sequence in progress |
| finish_o | output | 1 | One-cycle pulse at the end of a sequence |
| result_o | output | 3 | 0 ok, 1 bad image, 2 init timeout, 3 write error, 4 done timeout |

## Verification
The bench builds the loader with POLL_CYCLES=2, PROG_TICKS=2, INIT_POLLS=4, TX_POLLS=3, WRITE_DELAY_TICKS=2, DONE_POLLS=5 and MAX_TRIES=3. With these values, every timeout path (init, tx-ready, done) runs out within a few dozen cycles. All three attempts of a failing sequence can therefore be observed, as can recovery on the second attempt. The short poll interval also makes the program pulse width an exact small number (3 cycles), which the bench measures on every attempt.

// File: rtl/cfg_loader_pkg.sv
// Shared types for the configuration stream loader.
// Assumes: used by cfg_stream_loader and its submodules only.
package cfg_loader_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_REWIND, ST_VALIDATE, ST_PROG, ST_WAIT_INIT, ST_SKIP,
        ST_LOAD_HI, ST_LOAD_LO, ST_PACE, ST_WRITE, ST_CHECK, ST_WAIT_DONE
    } ld_state_e;

    typedef enum logic [2:0] {
        RES_OK           = 3'd0,
        RES_BAD_IMAGE    = 3'd1,
        RES_INIT_TIMEOUT = 3'd2,
        RES_WRITE_ERR    = 3'd3,
        RES_DONE_TIMEOUT = 3'd4
    } ld_result_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cfg_poll_timer.sv
// Poll pacer: raises poll_o once every POLL_CYCLES cycles, starting in the
// first cycle after clear_i. It counts polls and flags the poll that is
// numbered limit_i.
// Assumes: limit_i >= 1 and stays constant between clears.
module cfg_poll_timer #(
    parameter int POLL_CYCLES = 100,
    parameter int CW          = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic [CW-1:0] limit_i,
    output logic          poll_o,
    output logic          exhausted_o
);
    localparam int TW = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;

    logic [TW-1:0] tmr;
    logic [CW-1:0] pcnt;

    assign poll_o      = (tmr == '0);
    assign exhausted_o = (pcnt == limit_i - CW'(1));

    // Cycle counter that wraps once per poll interval.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)                 tmr <= '0;
        else if (tmr == TW'(POLL_CYCLES - 1))  tmr <= '0;
        else                                   tmr <= tmr + TW'(1);
    end

    // Counts the polls made since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) pcnt <= '0;
        else if (poll_o)       pcnt <= pcnt + CW'(1);
    end
endmodule

// File: rtl/cfg_marker_scan.sv
// Start-marker detector: finds the first 0xFF byte that is directly followed
// by 0x20, and tracks the parity of the byte count from that 0xFF onward.
// Assumes: clear_i is pulsed before each pass over the image.
module cfg_marker_scan (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       take_i,
    input  logic [7:0] byte_i,
    output logic       hit_o,
    output logic       found_o,
    output logic       odd_o
);
    logic prev_ff;

    assign hit_o = take_i && !found_o && prev_ff && (byte_i == 8'h20);

    // Remembers the previous byte, the marker state and the remainder parity.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            prev_ff <= 1'b0;
            found_o <= 1'b0;
            odd_o   <= 1'b0;
        end else if (take_i) begin
            prev_ff <= (byte_i == 8'hFF);
            if (hit_o)        found_o <= 1'b1;
            else if (found_o) odd_o   <= ~odd_o;
        end
    end
endmodule

// File: rtl/cfg_stream_loader.sv
// Configuration stream loader. It validates the image, then pulses program,
// waits for init, replays the image and writes each 16-bit word under a
// status handshake. It then waits for done, and retries a failed attempt.
// Assumes: the byte source restarts from byte 0 on rewind_o and presents the
// same image on every pass.
module cfg_stream_loader
    import cfg_loader_pkg::*;
#(
    parameter int POLL_CYCLES       = 100,
    parameter int PROG_TICKS        = 10,
    parameter int INIT_POLLS        = 50,
    parameter int TX_POLLS          = 100,
    parameter int WRITE_DELAY_TICKS = 2,
    parameter int DONE_POLLS        = 200,
    parameter int MAX_TRIES         = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        s_valid_i,
    input  logic [7:0]  s_data_i,
    input  logic        s_last_i,
    output logic        s_ready_o,
    output logic        rewind_o,
    output logic        prog_o,
    input  logic [15:0] dev_status_i,
    input  logic        dev_done_i,
    output logic        wr_en_o,
    output logic [15:0] wr_data_o,
    output logic        busy_o,
    output logic        finish_o,
    output logic [2:0]  result_o
);
    localparam int LIM_MAX = max2(max2(max2(PROG_TICKS, INIT_POLLS), max2(TX_POLLS, DONE_POLLS)),
                                  WRITE_DELAY_TICKS);
    localparam int CW      = $clog2(LIM_MAX + 1);
    localparam int AW      = $clog2(MAX_TRIES + 1);
    localparam int INIT_BIT  = 1;
    localparam int TXRDY_BIT = 2;
    localparam logic [3:0] NEW_SIG = 4'h5;

    ld_state_e     state, state_n;
    ld_result_e    fail_code;
    logic          fail, succeed, bad;
    logic [AW-1:0] attempt;
    logic          validating, new_dev, last_word;
    logic [15:0]   word;
    logic [CW-1:0] limit;
    logic          poll, exhausted, take, hit, found, odd;
    logic          init_ok, tx_ok;

    wire unused_status = ^{dev_status_i[11:3], dev_status_i[0]};

    assign init_ok   = dev_status_i[INIT_BIT];
    assign tx_ok     = dev_status_i[TXRDY_BIT];
    assign s_ready_o = (state == ST_VALIDATE) || (state == ST_SKIP) ||
                       (state == ST_LOAD_HI)  || (state == ST_LOAD_LO);
    assign take      = s_valid_i && s_ready_o;
    assign rewind_o  = (state == ST_REWIND);
    assign prog_o    = (state == ST_PROG);
    assign wr_en_o   = (state == ST_WRITE);
    assign wr_data_o = word;
    assign busy_o    = (state != ST_IDLE);

    cfg_poll_timer #(.POLL_CYCLES(POLL_CYCLES), .CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear_i(state_n != state), .limit_i(limit),
        .poll_o(poll), .exhausted_o(exhausted)
    );

    cfg_marker_scan u_scan (
        .clk(clk), .rst_n(rst_n), .clear_i(state == ST_REWIND), .take_i(take),
        .byte_i(s_data_i), .hit_o(hit), .found_o(found), .odd_o(odd)
    );

    // Selects the poll or delay limit that the current state waits on.
    always_comb begin
        case (state)
            ST_PROG:      limit = CW'(PROG_TICKS);
            ST_WAIT_INIT: limit = CW'(INIT_POLLS);
            ST_PACE:      limit = new_dev ? CW'(TX_POLLS) : CW'(WRITE_DELAY_TICKS);
            ST_WAIT_DONE: limit = CW'(DONE_POLLS);
            default:      limit = CW'(1);
        endcase
    end

    // Next-state logic and the outcome events of the sequence.
    always_comb begin
        state_n   = state;
        fail      = 1'b0;
        fail_code = RES_OK;
        succeed   = 1'b0;
        bad       = 1'b0;
        case (state)
            ST_IDLE:     if (start_i) state_n = ST_REWIND;
            ST_REWIND:   state_n = validating ? ST_VALIDATE : ST_SKIP;
            ST_VALIDATE: if (take && s_last_i) begin
                             if (!(found || hit) || (found && !odd)) bad = 1'b1;
                             else state_n = ST_PROG;
                         end
            ST_PROG:     if (poll && exhausted) state_n = ST_WAIT_INIT;
            ST_WAIT_INIT: if (poll) begin
                             if (init_ok) state_n = ST_REWIND;
                             else if (exhausted) begin
                                 fail = 1'b1; fail_code = RES_INIT_TIMEOUT;
                             end
                         end
            ST_SKIP:     if (take) begin
                             if (hit) state_n = ST_PACE;
                             else if (s_last_i) bad = 1'b1;
                         end
            ST_LOAD_HI:  if (take) begin
                             if (s_last_i) bad = 1'b1;
                             else state_n = ST_LOAD_LO;
                         end
            ST_LOAD_LO:  if (take) state_n = ST_PACE;
            ST_PACE:     if (new_dev) begin
                             if (poll && tx_ok) state_n = ST_WRITE;
                             else if (poll && exhausted) begin
                                 fail = 1'b1; fail_code = RES_WRITE_ERR;
                             end
                         end else if (poll && exhausted) state_n = ST_WRITE;
            ST_WRITE:    state_n = ST_CHECK;
            ST_CHECK:    if (!init_ok) begin
                             fail = 1'b1; fail_code = RES_WRITE_ERR;
                         end else state_n = last_word ? ST_WAIT_DONE : ST_LOAD_HI;
            ST_WAIT_DONE: if (poll) begin
                             if (dev_done_i) succeed = 1'b1;
                             else if (exhausted) begin
                                 fail = 1'b1; fail_code = RES_DONE_TIMEOUT;
                             end
                         end
            default:     state_n = ST_IDLE;
        endcase
        if (bad || succeed) state_n = ST_IDLE;
        if (fail) state_n = (attempt == AW'(MAX_TRIES - 1)) ? ST_IDLE : ST_PROG;
    end

    // Sequence registers: state, word assembly, attempt count and result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            attempt    <= '0;
            validating <= 1'b0;
            new_dev    <= 1'b0;
            last_word  <= 1'b0;
            word       <= '0;
            finish_o   <= 1'b0;
            result_o   <= RES_OK;
        end else begin
            state    <= state_n;
            finish_o <= 1'b0;
            if (state == ST_IDLE && start_i) begin
                result_o   <= RES_OK;
                attempt    <= '0;
                validating <= 1'b1;
            end
            if (state == ST_VALIDATE && state_n == ST_PROG) validating <= 1'b0;
            if (state == ST_WAIT_INIT && poll && init_ok)
                new_dev <= (dev_status_i[15:12] == NEW_SIG);
            if (state == ST_SKIP && hit) begin
                word      <= 16'hFF20;
                last_word <= s_last_i;
            end
            if (state == ST_LOAD_HI && take) word[15:8] <= s_data_i;
            if (state == ST_LOAD_LO && take) begin
                word[7:0] <= s_data_i;
                last_word <= s_last_i;
            end
            if (bad) begin
                result_o <= RES_BAD_IMAGE;
                finish_o <= 1'b1;
            end
            if (succeed) begin
                result_o <= RES_OK;
                finish_o <= 1'b1;
            end
            if (fail) begin
                result_o <= fail_code;
                if (attempt == AW'(MAX_TRIES - 1)) finish_o <= 1'b1;
                else attempt <= attempt + AW'(1);
            end
        end
    end
endmodule

// File: rtl/cfg_stream_loader_chk.sv
// Property checker for cfg_stream_loader, attached through bind.
// Assumes: connected to the loader's ports only.
module cfg_stream_loader_chk #(
    parameter int MAX_TRIES = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       s_ready_o,
    input logic       prog_o,
    input logic       wr_en_o,
    input logic       busy_o,
    input logic       finish_o,
    input logic [2:0] result_o
);
    logic [7:0] prog_cnt;
    logic       prog_q;

    // Counts program pulses since the last accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_cnt <= '0;
            prog_q   <= 1'b0;
        end else begin
            prog_q <= prog_o;
            if (start_i && !busy_o)    prog_cnt <= '0;
            else if (prog_o && !prog_q) prog_cnt <= prog_cnt + 8'd1;
        end
    end

    p_tries_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
        prog_cnt <= 8'(MAX_TRIES));
    p_bad_no_prog_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (finish_o && result_o == 3'd1) |-> (prog_cnt == 8'd0));
    p_idle_not_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !s_ready_o);
    p_result_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(result_o));
    p_finish_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        finish_o |-> !busy_o);
    p_write_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o);
endmodule

bind cfg_stream_loader cfg_stream_loader_chk #(.MAX_TRIES(MAX_TRIES)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .s_ready_o(s_ready_o),
    .prog_o(prog_o), .wr_en_o(wr_en_o), .busy_o(busy_o), .finish_o(finish_o),
    .result_o(result_o)
);

// File: tb/cfg_stream_loader_tb.sv
module cfg_stream_loader_tb;
    localparam int PC = 2, PT = 2;
    localparam int PROG_W = (PT - 1) * PC + 1;

    logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
    logic s_valid_i, s_last_i, s_ready_o, rewind_o, prog_o, dev_done_i;
    logic [7:0] s_data_i;
    logic [15:0] dev_status_i, wr_data_o;
    logic wr_en_o, busy_o, finish_o;
    logic [2:0] result_o;

    always #5 clk = ~clk;

    cfg_stream_loader #(.POLL_CYCLES(PC), .PROG_TICKS(PT), .INIT_POLLS(4), .TX_POLLS(3),
        .WRITE_DELAY_TICKS(2), .DONE_POLLS(5), .MAX_TRIES(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .s_valid_i(s_valid_i),
        .s_data_i(s_data_i), .s_last_i(s_last_i), .s_ready_o(s_ready_o),
        .rewind_o(rewind_o), .prog_o(prog_o), .dev_status_i(dev_status_i),
        .dev_done_i(dev_done_i), .wr_en_o(wr_en_o), .wr_data_o(wr_data_o),
        .busy_o(busy_o), .finish_o(finish_o), .result_o(result_o));

    int checks = 0, failures = 0;
    logic [7:0] img [0:31];
    int img_len = 0, idx = 0;
    int att = 0, wcnt = 0, pw = 0;
    logic prog_q = 1'b0;
    int init_fail_n = 0, done_fail_n = 0, wr_fail_at = 0;
    logic txrdy_cfg = 1'b1;
    logic [3:0] ver_cfg = 4'h5;
    logic [15:0] exp_q[$];

    // Byte source: replays from byte 0 on rewind.
    assign s_valid_i = idx < img_len;
    assign s_data_i  = (idx < img_len) ? img[idx[4:0]] : 8'h00;
    assign s_last_i  = (idx == img_len - 1);
    always @(posedge clk) begin
        if (rewind_o) idx <= 0;
        else if (s_valid_i && s_ready_o) idx <= idx + 1;
    end

    // Device model: counts attempts and words, drives status and done.
    always @(posedge clk) begin
        prog_q <= prog_o;
        if (start_i && !busy_o) att <= 0;
        else if (prog_o && !prog_q) att <= att + 1;
        if (prog_o) wcnt <= 0;
        else if (wr_en_o) wcnt <= wcnt + 1;
    end
    wire init_bit = !prog_o && (att > init_fail_n) && !(wr_fail_at > 0 && wcnt >= wr_fail_at);
    assign dev_status_i = {ver_cfg, 9'b0, txrdy_cfg, init_bit, 1'b0};
    assign dev_done_i   = (att > done_fail_n) && !prog_o;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Scoreboard monitor: compares written words and program pulse widths.
    always @(negedge clk) begin
        if (rst_n && wr_en_o) begin
            if (exp_q.size() == 0) check(1'b0, "R4 unexpected word", wr_data_o, 0);
            else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check(wr_data_o == e, "R1/R4 word value", wr_data_o, e);
            end
        end
        if (prog_o) pw++;
        else if (pw != 0) begin
            check(pw == PROG_W, "R5 program pulse width", pw, PROG_W);
            pw = 0;
        end
    end

    task automatic load(input logic [7:0] b[$]);
        foreach (b[i]) img[i] = b[i];
        img_len = b.size();
    endtask

    // Driver: computes expected words, starts a sequence, checks the outcome.
    task automatic run(input string tag, input int exp_res, input int exp_att,
                       input int words_per, input int wr_attempts);
        int m, n, t;
        logic [15:0] w[$];
        m = -1;
        for (int i = 0; i + 1 < img_len; i++)
            if (m < 0 && img[i] == 8'hFF && img[i+1] == 8'h20) m = i;
        if (m >= 0 && ((img_len - m) % 2 == 0))
            for (int i = m; i < img_len; i += 2) w.push_back({img[i], img[i+1]});
        n = (words_per < 0 || words_per > w.size()) ? w.size() : words_per;
        for (int a = 0; a < wr_attempts; a++)
            for (int i = 0; i < n; i++) exp_q.push_back(w[i]);
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        t = 0;
        while (!finish_o && t < 5000) begin
            @(negedge clk);
            t++;
        end
        check(t < 5000, {tag, " watchdog"}, t, 5000);
        check(result_o == exp_res[2:0], {tag, " result"}, result_o, exp_res);
        check(att == exp_att, {tag, " attempts"}, att, exp_att);
        check(exp_q.size() == 0, {tag, " words missing"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                failures++; checks++;
                $display("FAIL watchdog expired");
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        join_none
        load('{8'h00});
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !s_ready_o && !wr_en_o && !prog_o && result_o == 0,
              "R10/R11 reset state", {busy_o, s_ready_o, wr_en_o, prog_o}, 0);

        // R1 R4 R6 R8: header stripped, new device, success first try
        load('{8'h12, 8'h34, 8'hFF, 8'h20, 8'hAB, 8'hCD});
        init_fail_n = 0; done_fail_n = 0; wr_fail_at = 0; txrdy_cfg = 1; ver_cfg = 4'h5;
        run("R1 R4 R8 new-device success", 0, 1, -1, 1);
        // R1 R6: repeated 0xFF header, old device with fixed delay
        load('{8'hFF, 8'hFF, 8'h20, 8'h01, 8'h02, 8'h03, 8'h04});
        ver_cfg = 4'h3; txrdy_cfg = 0;
        run("R1 R6 old-device success", 0, 1, -1, 1);
        // R2: no marker
        load('{8'h01, 8'hFF, 8'h30, 8'h20});
        run("R2 missing marker", 1, 0, 0, 0);
        // R3: odd remainder
        load('{8'h07, 8'hFF, 8'h20, 8'h05});
        run("R3 odd remainder", 1, 0, 0, 0);
        // R5 R9: init never comes, all tries used
        load('{8'hFF, 8'h20, 8'h11, 8'h22});
        ver_cfg = 4'h5; txrdy_cfg = 1; init_fail_n = 3;
        run("R5 R9 init timeout", 2, 3, 0, 0);
        // R9: first attempt fails, second succeeds
        init_fail_n = 1;
        run("R9 retry success", 0, 2, -1, 1);
        // R7: init drops after first word on every attempt
        init_fail_n = 0; wr_fail_at = 1;
        run("R7 write error", 3, 3, 1, 3);
        // R6: tx-ready never seen on new device
        wr_fail_at = 0; txrdy_cfg = 0;
        run("R6 tx-ready timeout", 3, 3, 0, 0);
        // R8: done never seen
        txrdy_cfg = 1; done_fail_n = 99;
        run("R8 done timeout", 4, 3, -1, 3);
        // R10 R11: idle with data offered, result held, nothing consumed
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (s_ready_o || wr_en_o || result_o != 3'd4) begin
                check(1'b0, "R10/R11 idle hold", {s_ready_o, wr_en_o, result_o}, 4);
                break;
            end
        end
        check(result_o == 3'd4, "R10 result held", result_o, 4);
        // R9 R11: a later start replays the full image from byte 0
        done_fail_n = 0;
        run("R9 R11 rerun after idle", 0, 1, -1, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule